// File: doc/BRIEF.md
# DMA Control and Interrupt Register Core

This block is the register-level control core of a bus-master DMA engine. It sits behind a 32-bit register port. It holds the control register and the interrupt status register, and it follows two sticky flags: address-loaded and transfer-complete. From those flags it derives the "DMA running" status that lets the bus master request the bus, and a registered, active-low, level interrupt. It also emits the local-side soft reset and a one-cycle flush pulse toward the data queue. The address and byte counters, the bus protocol sequencer and the queue itself live outside this block. This block only sees a register write to the address offset, and a one-cycle transfer-done pulse that the counters raise.

Software arms a transfer by writing the control register first and the address register last. The address write sets address-loaded, and if DMA is enabled and no bus error is flagged, DMA-running rises. When the transfer ends, transfer-complete sets and address-loaded drops, which stops the engine. If interrupts are enabled, the interrupt line is pulled low one cycle later. Software acknowledges the completion by reading the interrupt status register, by flushing, or by writing a new address from the local side.

Register offsets (byte address on `reg_addr`): 0x0 control, 0x4 address counter, 0xC interrupt status. Reads of any other offset return zero.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After bus reset (`rst_n` low), the control register and the interrupt status register read 0 (with all status inputs idle). `irq_n` reads 1, `flush_pulse` reads 0, `dma_dir` reads 0 and `dma_running` reads 0.
- R2: Control register layout. Bit 0 is interrupt enable, bit 2 is local reset, bit 3 is direction, bit 4 is DMA enable and bit 5 is completion-interrupt disable; each of these reads back the value written. Bit 1 always reads 0. Bit 6 reads the DMA-running status. Bits 31..7 read 0.
- R3: A control write with bit 1 set clears transfer-complete and address-loaded at that write's clock edge. It also drives `flush_pulse` high for exactly the following cycle.
- R4: `local_rst_n` is low while control bit 2 is 1 and while `rst_n` is low.
- R5: A write to offset 0x4 sets address-loaded, whether `wr_from_local` is 1 or 0.
- R6: `dma_running` (and control bit 6) is 1 exactly when address-loaded is 1, control bit 4 is 1, and none of the three bus error inputs is 1.
- R7: Interrupt status layout. Bit 0 is the OR of error-pending, local request and transfer-complete, regardless of the enable bits. Bit 1 is the OR of `err_master_abort`, `err_target_abort` and `err_parity`. Bit 2 is 1 while `local_irq_n` is 0. Bit 3 is transfer-complete. Bit 4 is address-loaded. Bits 31..5 read 0.
- R8: Transfer-complete is cleared by a read of offset 0xC, by a flush, or by a write to offset 0x4 with `wr_from_local` = 1. A write to offset 0x4 with `wr_from_local` = 0 leaves it unchanged.
- R9: A `xfer_done` pulse sets transfer-complete and clears address-loaded, unless an address write lands in the same cycle, in which case address-loaded is set.
- R10: `irq_n` is registered. One cycle after the condition holds, it is 0 when control bit 0 is 1 and at least one of these holds: error-pending, local request, or transfer-complete with control bit 5 at 0. Otherwise it is 1.
- R11: When `xfer_done` coincides with any clear of transfer-complete, the flag ends up set.
- R12: `dma_dir` equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| wr_from_local | input | 1 | 1 when the write comes from the local side, 0 for a bus target access |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| local_irq_n | input | 1 | Active-low local interrupt request |
| err_master_abort | input | 1 | Bus status: master abort seen |
| err_target_abort | input | 1 | Bus status: target abort seen |
| err_parity | input | 1 | Bus status: parity error detected |
| xfer_done | input | 1 | One-cycle pulse from the counters at end of transfer |
| irq_n | output | 1 | Registered active-low level interrupt |
| local_rst_n | output | 1 | Active-low reset for the local side logic |
| flush_pulse | output | 1 | One-cycle queue flush request |
| dma_dir | output | 1 | Transfer direction, 1 = local side to bus |
| dma_running | output | 1 | Engine may request bus mastership |

## Verification
The in-line assertions check, on every cycle, the per-edge rules of the two flags: flush clears both flags, an address write arms the engine, a status read clears completion, a target-side address write keeps completion, and a transfer-done pulse wins over any clear. They also check that the flush pulse follows each flush write, that a disabled interrupt keeps `irq_n` high, and that the local reset and running status agree with their sources. The bench's sweeps are needed for the full register layouts and for every combination of enable, disable, error and request that decides `irq_n`. They also cover the cycle of latency on the interrupt line and the behaviour of coincident set and clear events, which the bench observes through reads at the ports.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

    // Control register bit positions (software-visible layout)
    localparam int CSR_IRQ_EN = 0;
    localparam int CSR_FLUSH  = 1;
    localparam int CSR_LRST   = 2;
    localparam int CSR_DIR    = 3;
    localparam int CSR_ENA    = 4;
    localparam int CSR_TC_DIS = 5;
    localparam int CSR_RUN    = 6;
    localparam int CSR_WR_W   = CSR_TC_DIS + 1;

    // Interrupt status register bit positions
    localparam int ISR_PEND = 0;
    localparam int ISR_ERR  = 1;
    localparam int ISR_LREQ = 2;
    localparam int ISR_TC   = 3;
    localparam int ISR_AD   = 4;
    localparam int ISR_W    = ISR_AD + 1;

    // Register byte offsets
    localparam int OFF_CSR = 0;
    localparam int OFF_ACR = 4;
    localparam int OFF_ISR = 12;

    typedef struct packed {
        logic irq_en;
        logic lrst;
        logic dir;
        logic ena;
        logic tc_dis;
    } ctrl_t;

    typedef struct packed {
        logic tc;
        logic ad;
    } flags_t;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              csr_wr,
    output logic              acr_wr,
    output logic              isr_rd
);

    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(OFF_CSR);
    localparam logic [ADDR_W-1:0] A_ACR = ADDR_W'(OFF_ACR);
    localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFF_ISR);

    always_comb begin
        csr_wr = reg_wr && (reg_addr == A_CSR);
        acr_wr = reg_wr && (reg_addr == A_ACR);
        isr_rd = reg_rd && (reg_addr == A_ISR);
    end

endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic [CSR_WR_W-1:0] wdata,
    output ctrl_t               ctrl,
    output logic                flush_req,
    output logic                flush_pulse
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  flush;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        flush_req  = csr_wr && wdata[CSR_FLUSH];
        if (csr_wr) begin
            st_d.ctrl.irq_en = wdata[CSR_IRQ_EN];
            st_d.ctrl.lrst   = wdata[CSR_LRST];
            st_d.ctrl.dir    = wdata[CSR_DIR];
            st_d.ctrl.ena    = wdata[CSR_ENA];
            st_d.ctrl.tc_dis = wdata[CSR_TC_DIS];
            st_d.flush       = wdata[CSR_FLUSH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl        = st_q.ctrl;
    assign flush_pulse = st_q.flush;

    p_flush_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> flush_pulse);
    p_flush_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_req |=> !flush_pulse);
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> $stable(ctrl));

endmodule

// File: rtl/dma_flag_track.sv
module dma_flag_track
    import dma_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic acr_wr,
    input  logic acr_from_local,
    input  logic isr_rd,
    input  logic xfer_done,
    output logic tc,
    output logic ad_loaded
);

    flags_t fl_d, fl_q;
    logic   tc_clr;

    always_comb begin
        fl_d   = fl_q;
        tc_clr = isr_rd || flush_req || (acr_wr && acr_from_local);
        // completion: a set beats any clear in the same cycle
        if (xfer_done)   fl_d.tc = 1'b1;
        else if (tc_clr) fl_d.tc = 1'b0;
        // address-loaded: a new address beats the drop at completion
        if (acr_wr)                      fl_d.ad = 1'b1;
        else if (flush_req || xfer_done) fl_d.ad = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign tc        = fl_q.tc;
    assign ad_loaded = fl_q.ad;

    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !xfer_done) |=> (!tc && !ad_loaded));
    p_addr_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acr_wr |=> ad_loaded);
    p_isr_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !xfer_done) |=> !tc);
    p_target_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acr_wr && !acr_from_local && !isr_rd && tc) |=> tc);
    p_done_drops_ad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !acr_wr) |=> !ad_loaded);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> tc);

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic tc_dis,
    input  logic err,
    input  logic lreq,
    input  logic tc,
    output logic irq_n
);

    logic irq_n_d, irq_n_q;

    always_comb begin
        irq_n_d = !(irq_en && (err || lreq || (tc && !tc_dis)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= irq_n_d;
    end

    assign irq_n = irq_n_q;

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> irq_n);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !lreq && !tc) |=> irq_n);

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wr_from_local,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              local_irq_n,
    input  logic              err_master_abort,
    input  logic              err_target_abort,
    input  logic              err_parity,
    input  logic              xfer_done,
    output logic              irq_n,
    output logic              local_rst_n,
    output logic              flush_pulse,
    output logic              dma_dir,
    output logic              dma_running
);

    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(OFF_CSR);
    localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFF_ISR);

    logic  csr_wr, acr_wr, isr_rd;
    logic  flush_req;
    ctrl_t ctrl;
    logic  tc, ad_loaded;
    logic  err_pend, lreq;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:CSR_WR_W];

    dma_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .csr_wr   (csr_wr),
        .acr_wr   (acr_wr),
        .isr_rd   (isr_rd)
    );

    dma_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr      (csr_wr),
        .wdata       (reg_wdata[CSR_WR_W-1:0]),
        .ctrl        (ctrl),
        .flush_req   (flush_req),
        .flush_pulse (flush_pulse)
    );

    dma_flag_track u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_req      (flush_req),
        .acr_wr         (acr_wr),
        .acr_from_local (wr_from_local),
        .isr_rd         (isr_rd),
        .xfer_done      (xfer_done),
        .tc             (tc),
        .ad_loaded      (ad_loaded)
    );

    dma_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_en (ctrl.irq_en),
        .tc_dis (ctrl.tc_dis),
        .err    (err_pend),
        .lreq   (lreq),
        .tc     (tc),
        .irq_n  (irq_n)
    );

    always_comb begin
        err_pend    = err_master_abort || err_target_abort || err_parity;
        lreq        = !local_irq_n;
        dma_running = ad_loaded && ctrl.ena && !err_pend;
        dma_dir     = ctrl.dir;
        local_rst_n = rst_n && !ctrl.lrst;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CSR) begin
            reg_rdata[CSR_IRQ_EN] = ctrl.irq_en;
            reg_rdata[CSR_LRST]   = ctrl.lrst;
            reg_rdata[CSR_DIR]    = ctrl.dir;
            reg_rdata[CSR_ENA]    = ctrl.ena;
            reg_rdata[CSR_TC_DIS] = ctrl.tc_dis;
            reg_rdata[CSR_RUN]    = dma_running;
        end else if (reg_addr == A_ISR) begin
            reg_rdata[ISR_PEND] = err_pend || lreq || tc;
            reg_rdata[ISR_ERR]  = err_pend;
            reg_rdata[ISR_LREQ] = lreq;
            reg_rdata[ISR_TC]   = tc;
            reg_rdata[ISR_AD]   = ad_loaded;
        end
    end

    p_lrst_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lrst |-> !local_rst_n);
    p_run_needs_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_running |-> (ad_loaded && !err_master_abort && !err_target_abort && !err_parity));
    p_done_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !reg_wr) |=> !dma_running);

endmodule

// File: tb/dma_ctrl_regs_bench.sv
`timescale 1ns/1ps
module dma_ctrl_regs_bench;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] O_CSR = 4'h0;
    localparam logic [AW-1:0] O_ACR = 4'h4;
    localparam logic [AW-1:0] O_BCR = 4'h8;
    localparam logic [AW-1:0] O_ISR = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          wr_from_local = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic          local_irq_n = 1'b1;
    logic          e_ma = 1'b0, e_ta = 1'b0, e_par = 1'b0;
    logic          xfer_done = 1'b0;
    logic          irq_n, local_rst_n, flush_pulse, dma_dir, dma_running;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    dma_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW)) u_dma_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wr_from_local(wr_from_local),
        .reg_rdata(reg_rdata), .local_irq_n(local_irq_n),
        .err_master_abort(e_ma), .err_target_abort(e_ta), .err_parity(e_par),
        .xfer_done(xfer_done), .irq_n(irq_n), .local_rst_n(local_rst_n),
        .flush_pulse(flush_pulse), .dma_dir(dma_dir), .dma_running(dma_running)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic loc);
        reg_addr = a; reg_wdata = d; wr_from_local = loc; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    endtask

    function automatic logic [DW-1:0] isr_val(input logic err, input logic lq,
                                              input logic tc, input logic ad);
        return DW'({ad, tc, lq, err, err | lq | tc});
    endfunction

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        #1;
        // R1 / R4 during reset
        check("R4 rst", DW'(local_rst_n), 0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        peek(O_CSR, v); check("R1 csr", v, 0);
        peek(O_ISR, v); check("R1 isr", v, 0);
        peek(O_BCR, v); check("R1 other", v, 0);
        check("R1 irq_n", DW'(irq_n), 1);
        check("R1 flush", DW'(flush_pulse), 0);
        check("R1 dir", DW'(dma_dir), 0);
        check("R1 run", DW'(dma_running), 0);
        check("R4 out", DW'(local_rst_n), 1);

        // R2 R3 R4 R12: sweep every pattern of the six low control bits
        for (int m = 0; m < 64; m++) begin
            wr(O_CSR, 32'hABCD_0F80 | DW'(m), 1'b0);
            check("R3 pulse", DW'(flush_pulse), DW'(m[1]));
            peek(O_CSR, v); check("R2 csr", v, DW'(m) & 32'h3D);
            check("R4 lrst", DW'(local_rst_n), DW'(!m[2]));
            check("R12 dir", DW'(dma_dir), DW'(m[3]));
            tick();
            check("R3 single", DW'(flush_pulse), 0);
        end
        wr(O_CSR, 0, 1'b0);

        // R5 R6 R7: running status over enable, error inputs and arming
        for (int en = 0; en < 2; en++) begin
            for (int e = 0; e < 8; e++) begin
                for (int ad = 0; ad < 2; ad++) begin
                    logic ex_run, ex_err;
                    wr(O_CSR, 32'h2 | (DW'(en) << 4), 1'b0);
                    {e_par, e_ta, e_ma} = 3'(e);
                    if (ad != 0) wr(O_ACR, 32'h1000, 1'(e & 1));
                    ex_err = (e != 0);
                    ex_run = (ad != 0) && (en != 0) && !ex_err;
                    peek(O_ISR, v); check("R7 isr", v, isr_val(ex_err, 1'b0, 1'b0, 1'(ad)));
                    check("R5 R6 run", DW'(dma_running), DW'(ex_run));
                    peek(O_CSR, v); check("R6 bit6", v, (DW'(en) << 4) | (DW'(ex_run) << 6));
                    {e_par, e_ta, e_ma} = 3'b000;
                end
            end
        end

        // R8 R9 R11: completion flag paths
        wr(O_CSR, 32'h12, 1'b0);
        wr(O_ACR, 32'h40, 1'b0);
        check("R6 armed", DW'(dma_running), 1);
        pulse_done();
        peek(O_ISR, v); check("R9 done", v, isr_val(0, 0, 1, 0));
        check("R9 stop", DW'(dma_running), 0);
        wr(O_ACR, 32'h80, 1'b0);
        peek(O_ISR, v); check("R8 target keeps", v, isr_val(0, 0, 1, 1));
        rd(O_ISR, v); check("R8 read value", v, isr_val(0, 0, 1, 1));
        peek(O_ISR, v); check("R8 read clears", v, isr_val(0, 0, 0, 1));
        pulse_done();
        wr(O_ACR, 32'h80, 1'b1);
        peek(O_ISR, v); check("R8 local clears", v, isr_val(0, 0, 0, 1));
        pulse_done();
        wr(O_CSR, 32'h2, 1'b0);
        peek(O_ISR, v); check("R8 R3 flush clears", v, isr_val(0, 0, 0, 0));
        pulse_done();
        reg_addr = O_ISR; reg_rd = 1'b1; xfer_done = 1'b1;
        tick();
        reg_rd = 1'b0; xfer_done = 1'b0;
        peek(O_ISR, v); check("R11 read vs set", v, isr_val(0, 0, 1, 0));
        reg_addr = O_ACR; wr_from_local = 1'b1; reg_wr = 1'b1; xfer_done = 1'b1;
        tick();
        reg_wr = 1'b0; xfer_done = 1'b0;
        peek(O_ISR, v); check("R11 R9 addr vs set", v, isr_val(0, 0, 1, 1));
        wr(O_CSR, 32'h2, 1'b0);

        // R10 latency
        wr(O_CSR, 32'h1, 1'b0);
        check("R10 idle", DW'(irq_n), 1);
        local_irq_n = 1'b0; #1;
        check("R10 not yet", DW'(irq_n), 1);
        tick();
        check("R10 one cycle", DW'(irq_n), 0);
        local_irq_n = 1'b1;
        tick();
        check("R10 release", DW'(irq_n), 1);

        // R7 R10: all combinations of enable, disable, error, request, completion
        for (int m = 0; m < 32; m++) begin
            logic ie, td, er, lq, tcx, ex_irq;
            {tcx, lq, er, td, ie} = 5'(m);
            wr(O_CSR, 32'h2 | DW'(ie) | (DW'(td) << 5), 1'b0);
            if (tcx) pulse_done();
            e_ta = er; local_irq_n = !lq;
            tick();
            ex_irq = ie && (er || lq || (tcx && !td));
            check("R10 irq", DW'(irq_n), DW'(!ex_irq));
            peek(O_ISR, v); check("R7 sum", v, isr_val(er, lq, tcx, 1'b0));
            e_ta = 1'b0; local_irq_n = 1'b1;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule